// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes four active-low, level-type PCI interrupt inputs (lines A, B, C and D) and routes them onto sixteen active-high legacy IRQ request lines. Each input has a 4-bit steering code. That code either names the IRQ number the input drives, or disables the input. Some code values are reserved, and a reserved code drives no IRQ line.

The steering codes are kept in two byte-wide configuration registers. Software reaches them through a simple byte read/write port. A write takes effect on the next clock edge. A read returns exactly the byte that was stored, including any reserved codes. Each input first passes through a two-flop synchronizer. The decoded requests are then merged with a logical OR, so several inputs can share one IRQ. The merged result is registered before it reaches the output.

Top module: `irq_steer_router`

## Requirements
- R1: Out of reset, both steering registers read 00h and every irq_req bit is 0.
- R2: Register layout. At address 0, bits 3:0 steer line A and bits 7:4 steer line B. At address 1, bits 3:0 steer line C and bits 7:4 steer line D.
- R3: Codes 1, 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15 route an asserted input to the irq_req bit with the same index.
- R4: Code 0 disables the input. The input then drives no irq_req bit.
- R5: Codes 2, 8 and 13 are reserved. An input holding a reserved code drives no irq_req bit.
- R6: irq_req bits 0, 2, 8 and 13 are never asserted.
- R7: When several asserted inputs select the same IRQ, that irq_req bit is the OR of all of them.
- R8: Requests are level-type. An irq_req bit stays at 1 for every cycle that a mapped input is held low. It returns to 0 after every mapped input is released.
- R9: A change on int_n shows on irq_req after the third rising clock edge that follows it. The first two edges pass through the synchronizer and the third loads the output register.
- R10: A write changes the routing from the next clock edge on. cfg_rdata is registered: it shows the byte at cfg_addr one edge after the address is presented, and it returns the stored byte exactly, reserved codes included.
- R11: An input held high (inactive) drives no irq_req bit, whatever its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the steering registers |
| cfg_addr | input | 1 | Steering register select (0: lines A/B, 1: lines C/D) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data of the selected register |
| int_n | input | 4 | Active-low interrupt inputs; bit 0 is A, bit 3 is D |
| irq_req | output | 16 | Active-high IRQ requests, bit n is IRQ n |

## Verification
The assertions check four things on every cycle. First, irq_req is cleared on the edge after reset. Second, IRQ lines 0, 2, 8 and 13 stay quiet. Third, at most one request can be active per input, and no request appears when no synchronized input was active. Fourth, a write is returned exactly on a later read of the same address.

The correctness of the code-to-IRQ mapping can only be shown by the bench's scenarios, which are compared against a behavioural model. The same holds for the exact three-edge latency, the OR of shared lines, and the holding of a level while a pin stays low. These scenarios sweep all sixteen codes, share one IRQ among all four lines, and hold an input low across many cycles.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  // True when a steering code maps onto a real IRQ line.
  // Code 0 disables the input; codes 2, 8 and 13 are reserved.
  function automatic logic code_routable(input logic [3:0] code);
    case (code)
      4'd0, 4'd2, 4'd8, 4'd13: code_routable = 1'b0;
      default:                 code_routable = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/irq_steer_cfg_regs.sv
module irq_steer_cfg_regs #(
  parameter int NUM_REGS = 2,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[addr];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = mem[g];
  end

endmodule

// File: rtl/irq_steer_sync.sv
module irq_steer_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_n,
  output logic [WIDTH-1:0] active
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= ~raw_n;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign active = stg[STAGES-1];

endmodule

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int SEL_W   = 4,
  parameter int NUM_IRQ = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_INT-1:0]       active,
  input  logic [NUM_INT*SEL_W-1:0] sel_flat,
  output logic [NUM_IRQ-1:0]       irq_out
);

  logic [NUM_IRQ-1:0] hit [NUM_INT];
  logic [NUM_IRQ-1:0] merged;

  for (genvar i = 0; i < NUM_INT; i++) begin : g_line
    logic [SEL_W-1:0] code;
    assign code = sel_flat[i*SEL_W +: SEL_W];
    always_comb begin
      hit[i] = '0;
      if (active[i] && code_routable(code)) hit[i][code] = 1'b1;
    end
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_INT; i++) merged = merged | hit[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= merged;
  end

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router #(
  parameter int NUM_INT     = 4,
  parameter int SEL_W       = 4,
  parameter int NUM_IRQ     = 16,
  parameter int CFG_DW      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_PER_REG = CFG_DW / SEL_W,
  localparam int NUM_REGS    = NUM_INT / SEL_PER_REG,
  localparam int ADDR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr_en,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [CFG_DW-1:0]  cfg_rdata,
  input  logic [NUM_INT-1:0] int_n,
  output logic [NUM_IRQ-1:0] irq_req
);

  logic [NUM_REGS*CFG_DW-1:0] regs_flat;
  logic [NUM_INT-1:0]         int_act;

  irq_steer_cfg_regs #(.NUM_REGS(NUM_REGS), .DATA_W(CFG_DW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .regs_flat(regs_flat)
  );

  irq_steer_sync #(.WIDTH(NUM_INT), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .raw_n(int_n), .active(int_act)
  );

  irq_steer_decode #(.NUM_INT(NUM_INT), .SEL_W(SEL_W), .NUM_IRQ(NUM_IRQ)) dec_i (
    .clk(clk), .rst(rst), .active(int_act),
    .sel_flat(regs_flat[NUM_INT*SEL_W-1:0]), .irq_out(irq_req)
  );

endmodule

// File: rtl/irq_steer_router_chk.sv
module irq_steer_router_chk #(
  parameter int NUM_INT = 4,
  parameter int NUM_IRQ = 16,
  parameter int CFG_DW  = 8,
  parameter int ADDR_W  = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_wr_en,
  input logic [ADDR_W-1:0]  cfg_addr,
  input logic [CFG_DW-1:0]  cfg_wdata,
  input logic [CFG_DW-1:0]  cfg_rdata,
  input logic [NUM_INT-1:0] int_act,
  input logic [NUM_IRQ-1:0] irq_req
);

  localparam logic [NUM_IRQ-1:0] QUIET = NUM_IRQ'((1 << 0) | (1 << 2) | (1 << 8) | (1 << 13));

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq_req == '0);

  a_r6_quiet_lines: assert property (@(posedge clk) disable iff (rst)
    (irq_req & QUIET) == '0);

  a_r7_at_most_one_per_input: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_req) <= NUM_INT);

  a_r11_idle_no_request: assert property (@(posedge clk) disable iff (rst)
    ($past(int_act) == '0) |-> irq_req == '0);

  a_r10_readback: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_wr_en) && !cfg_wr_en && cfg_addr == $past(cfg_addr))
      |=> cfg_rdata == $past(cfg_wdata, 2));

endmodule

bind irq_steer_router irq_steer_router_chk #(
  .NUM_INT(NUM_INT), .NUM_IRQ(NUM_IRQ), .CFG_DW(CFG_DW), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .int_act(int_act),
  .irq_req(irq_req)
);

// File: tb/irq_steer_router_tb.sv
module irq_steer_router_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_en = 1'b0;
  logic [0:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] int_n = 4'hF;
  logic [15:0] irq_req;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_steer_router dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .int_n(int_n),
    .irq_req(irq_req)
  );

  // Behavioural reference model
  logic [7:0]  m_reg [2];
  logic [3:0]  m_s1, m_s2;
  logic [15:0] m_irq;
  logic [7:0]  m_rd;

  function automatic logic [15:0] route(input logic [3:0] act, input logic [7:0] r0,
                                        input logic [7:0] r1);
    logic [15:0] res = '0;
    logic [15:0] codes = {r1, r0};
    for (int i = 0; i < 4; i++) begin
      int c = int'(codes[i*4 +: 4]);
      if (act[i] && c != 0 && c != 2 && c != 8 && c != 13) res[c] = 1'b1;
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg[0] <= '0; m_reg[1] <= '0;
      m_s1 <= '0; m_s2 <= '0; m_irq <= '0; m_rd <= '0;
    end else begin
      if (cfg_wr_en) m_reg[cfg_addr] <= cfg_wdata;
      m_rd  <= m_reg[cfg_addr];
      m_s1  <= ~int_n;
      m_s2  <= m_s1;
      m_irq <= route(m_s2, m_reg[0], m_reg[1]);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check(phase, 32'(irq_req), 32'(m_irq));
      check(phase, 32'(cfg_rdata), 32'(m_rd));
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic a, input logic [7:0] exp);
    cfg_addr = a;
    @(negedge clk);
    check(req, 32'(cfg_rdata), 32'(exp));
  endtask

  function automatic logic [15:0] one_code(input int c);
    if (c == 0 || c == 2 || c == 8 || c == 13) return '0;
    return 16'(1) << c;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", 32'(irq_req), 0);
    rd_check("R1", 1'b0, 8'h00);
    rd_check("R1", 1'b1, 8'h00);
    cmp_en = 1'b1;

    // R11: inputs high with routing configured give nothing
    phase = "R11";
    wr(1'b0, 8'h53); wr(1'b1, 8'hEC);
    repeat (5) @(negedge clk);
    check("R11", 32'(irq_req), 0);

    // R2/R3: all lines low, each code lands on its own IRQ
    phase = "R2";
    int_n = 4'h0;
    repeat (4) @(negedge clk);
    check("R2", 32'(irq_req), 32'(16'h5028)); // 3,5,12,14

    // R9: latency of three edges
    phase = "R9";
    int_n = 4'hF;
    repeat (4) @(negedge clk);
    wr(1'b0, 8'h03); wr(1'b1, 8'h00);
    @(negedge clk);
    int_n = 4'b1110;
    @(negedge clk); check("R9", 32'(irq_req[3]), 0);
    @(negedge clk); check("R9", 32'(irq_req[3]), 0);
    @(negedge clk); check("R9", 32'(irq_req[3]), 1);

    // R8: level hold then release
    phase = "R8";
    repeat (20) @(negedge clk);
    check("R8", 32'(irq_req[3]), 1);
    int_n = 4'hF;
    repeat (4) @(negedge clk);
    check("R8", 32'(irq_req), 0);

    // Sweep of every code on line A (R3, R4, R5, R6, R10)
    int_n = 4'b1110;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 16; c++) begin
      string tag;
      tag = (c == 0) ? "R4" : (c == 2 || c == 8 || c == 13) ? "R5" : "R3";
      phase = tag;
      wr(1'b0, 8'(c));
      @(negedge clk);
      check(tag, 32'(irq_req), 32'(one_code(c)));
      check("R6", 32'(irq_req & 16'h2105), 0);
    end

    // R10: reserved codes read back exactly, routing follows next edge
    phase = "R10";
    wr(1'b1, 8'hD8);
    rd_check("R10", 1'b1, 8'hD8);
    wr(1'b0, 8'h0D);
    rd_check("R10", 1'b0, 8'h0D);
    check("R10", 32'(irq_req), 0);

    // R7: all four lines share IRQ9
    phase = "R7";
    wr(1'b0, 8'h99); wr(1'b1, 8'h99);
    int_n = 4'b0111;
    repeat (4) @(negedge clk);
    check("R7", 32'(irq_req), 32'(16'h0200));
    int_n = 4'b1010;
    repeat (4) @(negedge clk);
    check("R7", 32'(irq_req), 32'(16'h0200));
    int_n = 4'b1111;
    repeat (4) @(negedge clk);
    check("R7", 32'(irq_req), 0);

    // R4: all lines disabled, all pins low
    phase = "R4";
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    int_n = 4'h0;
    repeat (5) @(negedge clk);
    check("R4", 32'(irq_req), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule